// File: doc/BRIEF.md
# On-Chip Scan Clock Controller

This block sits between the clock sources and the scan flip-flops of several clock domains for at-speed test. Each domain has its own fast clock from a PLL. All domains share one free-running slow clock from the tester. While scan data is shifted, every domain output carries the slow clock. When scan enable drops for a capture, each domain's output is handed over to its fast clock. The block then lets through a short burst of fast pulses: the first pulse launches the transition and the second captures it. A per-domain enable bit, loaded earlier from a clock-control chain, decides whether a domain gets its burst at all. After the burst the output stays low until scan enable returns high. The output then goes back to the slow clock.

Each domain has its own pieces. A synchronizer brings the capture request into the fast domain. A small state machine counts the burst. A clock-gate cell, latched while the clock is low, opens the fast clock. A glitch-free two-way multiplexer uses cross-locked enables, so one source must be switched off before the other is switched on. Two static overrides sit in front of all this. With test mode low, every output is its raw fast clock. With test mode high and PLL bypass high, every output is the slow clock. The slow clock must be a free-running oscillator that is used only by this controller and is never also routed to the flip-flops as an external scan clock.

Top module: `occ_scan_clk_ctrl`

## Requirements
- R1: While `rst` is high with `test_mode` high and `pll_bypass` low, every `clk_out` bit follows `slow_clk` and carries no fast pulses, whatever the level of `scan_en`.
- R2: While `test_mode` is low, `clk_out[i]` equals `fast_clk[i]` for every domain, regardless of `rst`, `scan_en`, `pll_bypass` and `clk_enable`.
- R3: While `test_mode` and `pll_bypass` are both high, every `clk_out` bit equals `slow_clk`, regardless of `scan_en`.
- R4: In test mode without bypass, while `scan_en` is high (shift), every `clk_out` bit carries the slow clock, one output rising edge per `slow_clk` rising edge.
- R5: After `scan_en` falls in test mode without bypass, a domain whose `clk_enable` bit is 1 emits exactly `PULSES` fast pulses (default 2: launch, then capture), and its output then stays low until `scan_en` rises. No burst ever exceeds `PULSES` pulses.
- R6: A domain whose `clk_enable` bit is 0 emits no pulse during the capture burst, yet still receives slow shift clocks once `scan_en` is high again.
- R7: Every high and every low phase seen on `clk_out[i]` is at least half a period of `fast_clk[i]` long, including across the slow-to-fast and fast-to-slow hand-overs.
- R8: Within a domain, the slow path and the fast path of the multiplexer are never enabled together, and a fast pulse passes the gate only while the fast path is selected. As a result, no slow edge follows the hand-over inside the capture window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Active-high reset; holds every domain's controller in its idle state |
| test_mode | input | 1 | 1: controlled test clocking; 0: raw fast clocks pass through |
| pll_bypass | input | 1 | In test mode, 1 forces the slow clock on every output |
| scan_en | input | 1 | 1: shift (slow clock); falling edge requests a capture burst |
| clk_enable | input | DOMAINS | Per-domain capture enable bits from the clock-control chain |
| fast_clk | input | DOMAINS | Per-domain fast clocks from the PLL |
| slow_clk | input | 1 | Free-running slow tester clock |
| clk_out | output | DOMAINS | Clocks delivered to each domain's scan flip-flops |

## Verification
When `scan_en` falls just after a slow rising edge, the synchronizers see the request within two fast cycles. The slow path still lets through the pulse that starts 40 ns after that edge, and it shuts at the following falling edge of the slow clock, 60 ns after the edge. The bench therefore opens its capture window 60 ns after the aligned fall and counts pulses for 600 ns. That window covers the fast hand-over (one fast cycle), the arm cycle and the `PULSES` gate cycles, each of which leads by one cycle to a pulse on the next rising edge. When `scan_en` rises, the fast path closes within three fast cycles and the slow path reopens within two slow cycles. Shift clocks are therefore counted only after a 200 ns settle, and every count window starts 0.3 ns after a slow rising edge, so that no window boundary coincides with any clock edge. Pulse widths are watched continuously from each mode change onward, hand-overs included, and compared against half the domain's fast period.

// File: rtl/occ_pkg.sv
`timescale 1ns/1ps
package occ_pkg;
  // Per-domain capture burst sequencer states
  typedef enum logic [1:0] {
    BST_IDLE = 2'd0,  // shift or quiet, gate closed
    BST_ARM  = 2'd1,  // capture requested, waiting for fast path
    BST_FIRE = 2'd2,  // gate open, counting pulses
    BST_HOLD = 2'd3   // burst finished, output held low
  } burst_state_e;
endpackage

// File: rtl/occ_sync.sv
`timescale 1ns/1ps
module occ_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/occ_clk_gate.sv
`timescale 1ns/1ps
module occ_clk_gate (
  input  logic clk,
  input  logic en,
  output logic gclk,
  output logic gate_open
);
  logic en_l;

  // Enable only changes while the clock is low, so pulses are whole
  always_latch begin
    if (!clk) en_l = en;
  end

  assign gclk      = clk & en_l;
  assign gate_open = en_l;
endmodule

// File: rtl/occ_burst_ctrl.sv
`timescale 1ns/1ps
module occ_burst_ctrl
  import occ_pkg::*;
#(
  parameter int PULSES      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic fast_clk,
  input  logic rst,
  input  logic capture_req,   // asynchronous, level
  input  logic fast_path_on,  // multiplexer has selected the fast source
  input  logic pulse_allow,   // clock-chain enable bit for this domain
  output logic want_fast,
  output logic gate_en
);
  localparam int CNT_W = (PULSES > 1) ? $clog2(PULSES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSES - 1);

  burst_state_e      state;
  logic [CNT_W-1:0]  cnt;
  logic              gate_q;

  occ_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk (fast_clk),
    .rst (rst),
    .d   (capture_req),
    .q   (want_fast)
  );

  always_ff @(posedge fast_clk) begin
    if (rst || !want_fast) begin
      state  <= BST_IDLE;
      cnt    <= '0;
      gate_q <= 1'b0;
    end else begin
      case (state)
        BST_IDLE: begin
          state  <= BST_ARM;
          gate_q <= 1'b0;
        end
        BST_ARM: begin
          if (fast_path_on) begin
            state  <= BST_FIRE;
            cnt    <= '0;
            gate_q <= pulse_allow;
          end
        end
        BST_FIRE: begin
          if (cnt == LAST) begin
            state  <= BST_HOLD;
            gate_q <= 1'b0;
          end else begin
            cnt    <= cnt + 1'b1;
            gate_q <= pulse_allow;
          end
        end
        default: begin
          gate_q <= 1'b0;
        end
      endcase
    end
  end

  assign gate_en = gate_q;
endmodule

// File: rtl/occ_glitch_mux.sv
`timescale 1ns/1ps
module occ_glitch_mux (
  input  logic rst,
  input  logic slow_clk,
  input  logic fast_ref,    // free fast clock, times the fast-side enable
  input  logic fast_gated,  // gated fast clock to forward
  input  logic want_fast,   // fast-domain request
  output logic clk_o,
  output logic slow_on,
  output logic fast_on
);
  logic fast_pre;
  logic slow_pre;

  // Fast side: request, locked out while the slow path is still on
  always_ff @(posedge fast_ref) begin
    if (rst) fast_pre <= 1'b0;
    else     fast_pre <= want_fast & ~slow_on;
  end

  always_ff @(negedge fast_ref) begin
    if (rst) fast_on <= 1'b0;
    else     fast_on <= fast_pre & ~slow_on;
  end

  // Slow side: released only once the fast path is off
  always_ff @(posedge slow_clk) begin
    if (rst) slow_pre <= 1'b1;
    else     slow_pre <= ~want_fast & ~fast_on;
  end

  always_ff @(negedge slow_clk) begin
    if (rst) slow_on <= 1'b1;
    else     slow_on <= slow_pre & ~fast_on;
  end

  assign clk_o = (slow_clk & slow_on) | (fast_gated & fast_on);
endmodule

// File: rtl/occ_scan_clk_ctrl.sv
`timescale 1ns/1ps
module occ_scan_clk_ctrl #(
  parameter int DOMAINS     = 2,
  parameter int PULSES      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               rst,
  input  logic               test_mode,
  input  logic               pll_bypass,
  input  logic               scan_en,
  input  logic [DOMAINS-1:0] clk_enable,
  input  logic [DOMAINS-1:0] fast_clk,
  input  logic               slow_clk,
  output logic [DOMAINS-1:0] clk_out
);
  logic               capture_req;
  logic [DOMAINS-1:0] want_v;
  logic [DOMAINS-1:0] gate_req_v;
  logic [DOMAINS-1:0] gate_v;
  logic [DOMAINS-1:0] gclk_v;
  logic [DOMAINS-1:0] slow_on_v;
  logic [DOMAINS-1:0] fast_on_v;
  logic [DOMAINS-1:0] mux_out_v;

  assign capture_req = test_mode & ~pll_bypass & ~scan_en;

  for (genvar d = 0; d < DOMAINS; d++) begin : g_dom
    occ_burst_ctrl #(
      .PULSES      (PULSES),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_burst (
      .fast_clk     (fast_clk[d]),
      .rst          (rst),
      .capture_req  (capture_req),
      .fast_path_on (fast_on_v[d]),
      .pulse_allow  (clk_enable[d]),
      .want_fast    (want_v[d]),
      .gate_en      (gate_req_v[d])
    );

    occ_clk_gate u_gate (
      .clk       (fast_clk[d]),
      .en        (gate_req_v[d]),
      .gclk      (gclk_v[d]),
      .gate_open (gate_v[d])
    );

    occ_glitch_mux u_mux (
      .rst        (rst),
      .slow_clk   (slow_clk),
      .fast_ref   (fast_clk[d]),
      .fast_gated (gclk_v[d]),
      .want_fast  (want_v[d]),
      .clk_o      (mux_out_v[d]),
      .slow_on    (slow_on_v[d]),
      .fast_on    (fast_on_v[d])
    );

    // Static overrides: functional pass-through, then PLL bypass
    always_comb begin
      if (!test_mode)      clk_out[d] = fast_clk[d];
      else if (pll_bypass) clk_out[d] = slow_clk;
      else                 clk_out[d] = mux_out_v[d];
    end
  end
endmodule

// File: rtl/occ_scan_clk_chk.sv
`timescale 1ns/1ps
module occ_scan_clk_chk #(
  parameter int DOMAINS = 2,
  parameter int PULSES  = 2
) (
  input logic               rst,
  input logic               test_mode,
  input logic               pll_bypass,
  input logic [DOMAINS-1:0] clk_enable,
  input logic [DOMAINS-1:0] fast_clk,
  input logic               slow_clk,
  input logic [DOMAINS-1:0] clk_out,
  input logic [DOMAINS-1:0] want_v,
  input logic [DOMAINS-1:0] gate_v,
  input logic [DOMAINS-1:0] slow_on_v,
  input logic [DOMAINS-1:0] fast_on_v
);
  for (genvar d = 0; d < DOMAINS; d++) begin : g_chk
    logic [7:0] burst_cnt;

    always_ff @(posedge fast_clk[d]) begin
      if (rst || !want_v[d])                   burst_cnt <= '0;
      else if (gate_v[d] && burst_cnt != 8'hFF) burst_cnt <= burst_cnt + 8'd1;
    end

    // R8
    mux_excl_chk: assert property (@(posedge slow_clk) disable iff (rst)
      !(slow_on_v[d] && fast_on_v[d]));

    // R8
    gate_path_chk: assert property (@(posedge fast_clk[d]) disable iff (rst)
      gate_v[d] |-> fast_on_v[d]);

    // R6
    gate_allow_chk: assert property (@(posedge fast_clk[d]) disable iff (rst)
      gate_v[d] |-> $past(clk_enable[d]));

    // R5
    burst_len_chk: assert property (@(posedge fast_clk[d]) disable iff (rst)
      int'(burst_cnt) <= PULSES);

    // R2
    func_pass_chk: assert property (@(negedge fast_clk[d]) disable iff (rst)
      !test_mode |-> clk_out[d]);

    // R3
    bypass_slow_chk: assert property (@(negedge slow_clk) disable iff (rst)
      (test_mode && pll_bypass) |-> clk_out[d]);
  end
endmodule

bind occ_scan_clk_ctrl occ_scan_clk_chk #(
  .DOMAINS (DOMAINS),
  .PULSES  (PULSES)
) u_chk (
  .rst        (rst),
  .test_mode  (test_mode),
  .pll_bypass (pll_bypass),
  .clk_enable (clk_enable),
  .fast_clk   (fast_clk),
  .slow_clk   (slow_clk),
  .clk_out    (clk_out),
  .want_v     (want_v),
  .gate_v     (gate_v),
  .slow_on_v  (slow_on_v),
  .fast_on_v  (fast_on_v)
);

// File: tb/sim_occ_scan_clk_ctrl.sv
`timescale 1ns/1ps
module sim_occ_scan_clk_ctrl;
  localparam int ND = 2;
  localparam int NP = 2;

  logic          rst = 1'b1;
  logic          test_mode = 1'b1;
  logic          pll_bypass = 1'b0;
  logic          scan_en = 1'b0;
  logic [ND-1:0] clk_enable = '0;
  logic [ND-1:0] fast_clk = '0;
  logic          slow_clk = 1'b0;
  logic [ND-1:0] clk_out;

  // domain 0: 200 MHz, domain 1: 7 ns, tester clock: 40 ns
  always #2.5 fast_clk[0] = ~fast_clk[0];
  always #3.5 fast_clk[1] = ~fast_clk[1];
  always #20  slow_clk    = ~slow_clk;

  occ_scan_clk_ctrl #(.DOMAINS(ND), .PULSES(NP)) u0 (
    .rst        (rst),
    .test_mode  (test_mode),
    .pll_bypass (pll_bypass),
    .scan_en    (scan_en),
    .clk_enable (clk_enable),
    .fast_clk   (fast_clk),
    .slow_clk   (slow_clk),
    .clk_out    (clk_out)
  );

  int      n_chk = 0;
  int      n_fail = 0;
  bit      done = 1'b0;
  int      out_edges [ND];
  int      fast_edges[ND];
  int      slow_edges;
  realtime t_rise[ND];
  realtime t_fall[ND];
  realtime min_hi[ND];
  realtime min_lo[ND];
  realtime half_per[ND];

  initial begin
    half_per[0] = 2.5;
    half_per[1] = 3.5;
  end

  always @(posedge slow_clk) slow_edges++;

  for (genvar g = 0; g < ND; g++) begin : g_mon
    always @(posedge fast_clk[g]) fast_edges[g]++;
    always @(posedge clk_out[g]) begin
      out_edges[g]++;
      if (t_fall[g] >= 0.0 && ($realtime - t_fall[g]) < min_lo[g])
        min_lo[g] = $realtime - t_fall[g];
      t_rise[g] = $realtime;
    end
    always @(negedge clk_out[g]) begin
      if (t_rise[g] >= 0.0 && ($realtime - t_rise[g]) < min_hi[g])
        min_hi[g] = $realtime - t_rise[g];
      t_fall[g] = $realtime;
    end
  end

  task automatic clear_counts();
    slow_edges = 0;
    for (int i = 0; i < ND; i++) begin
      out_edges[i]  = 0;
      fast_edges[i] = 0;
    end
  endtask

  task automatic clear_widths();
    for (int i = 0; i < ND; i++) begin
      t_rise[i] = -1.0;
      t_fall[i] = -1.0;
      min_hi[i] = 1.0e9;
      min_lo[i] = 1.0e9;
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_widths(input string tag);
    for (int i = 0; i < ND; i++) begin
      check(min_hi[i] >= half_per[i] - 0.05 && min_lo[i] >= half_per[i] - 0.05,
            "R7", $sformatf("%s domain %0d min phase (ps)", tag, i),
            int'((min_hi[i] < min_lo[i] ? min_hi[i] : min_lo[i]) * 1000.0),
            int'(half_per[i] * 1000.0));
    end
  endtask

  task automatic align_slow();
    @(posedge slow_clk);
    #0.3;
  endtask

  // count outputs over a window and compare each with slow or fast edges
  task automatic window_vs(input string req, input bit use_fast, input realtime dur);
    align_slow();
    clear_counts();
    #dur;
    for (int i = 0; i < ND; i++) begin
      int exp_v;
      exp_v = use_fast ? fast_edges[i] : slow_edges;
      check(out_edges[i] == exp_v, req, $sformatf("domain %0d edge count", i),
            out_edges[i], exp_v);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    clear_counts();
    clear_widths();

    // R1: reset with a pending capture request keeps slow clock only
    repeat (4) @(posedge slow_clk);
    clear_widths();
    window_vs("R1", 1'b0, 400.0);
    check_widths("reset");
    scan_en = 1'b1;
    repeat (3) @(posedge slow_clk);
    rst = 1'b0;

    // R4: shift
    #200;
    clear_widths();
    window_vs("R4", 1'b0, 400.0);
    check_widths("shift");

    // R2: functional pass-through ignores the other controls
    test_mode = 1'b0;
    for (int k = 0; k < 3; k++) begin
      scan_en    = 1'($urandom);
      pll_bypass = 1'($urandom);
      clk_enable = ND'($urandom);
      if (k == 2) rst = 1'b1;
      #50;
      window_vs("R2", 1'b1, 200.0);
    end
    rst = 1'b0;

    // R3: bypass forces slow clock whatever scan_en does
    test_mode  = 1'b1;
    pll_bypass = 1'b1;
    for (int k = 0; k < 3; k++) begin
      scan_en = (k == 0) ? 1'b0 : 1'($urandom);
      #100;
      window_vs("R3", 1'b0, 400.0);
    end
    pll_bypass = 1'b0;
    scan_en    = 1'b1;
    #300;

    // R5/R6/R8 capture bursts, directed then random enables
    for (int r = 0; r < 10; r++) begin
      logic [ND-1:0] en;
      if (r == 0)      en = '1;
      else if (r == 1) en = '0;
      else             en = ND'($urandom);
      clk_enable = en;
      align_slow();
      clear_widths();
      scan_en = 1'b0;
      #60;
      clear_counts();
      #600;
      for (int i = 0; i < ND; i++) begin
        int exp_p;
        exp_p = en[i] ? NP : 0;
        check(out_edges[i] == exp_p, en[i] ? "R5" : "R6",
              $sformatf("round %0d domain %0d capture pulses (R8 no slow edge)", r, i),
              out_edges[i], exp_p);
      end
      scan_en = 1'b1;
      #200;
      window_vs("R6", 1'b0, 400.0);
      check_widths($sformatf("round %0d", r));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule